// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger-Level Interrupts

This block sits between a serial shift engine and the processor-facing register port of a serial peripheral controller. It holds two byte queues: an outbound queue that software fills through a data register and the shift engine empties one byte at a time, and an inbound queue that the shift engine fills and software empties by reading a data register. Each queue reports its occupancy and can be emptied at once by a self-clearing flush bit.

Four interrupt sources feed a latched, write-one-to-clear pending register, each with its own enable bit. Two sources are level conditions taken from programmable thresholds: inbound data at or above its threshold, and outbound data at or below its threshold. The other two are events: a byte arriving while the inbound queue is full, and a completion pulse from the shift engine. A level condition that is still true comes back on the cycle after software clears it. Software must therefore refill or drain the queue before it clears the bit. The interrupt line is the OR of the enabled pending bits. The queue depth is a parameter, 64 or 128.

Top module: `spi_fifo_irq_top`

## Requirements
- R1: A register write to address 4 pushes `reg_wdata[7:0]` into the outbound queue. `tx_byte` shows the oldest byte. A `tx_pop` pulse removes it, and bytes leave in the order they were written. `tx_empty` is high when the queue holds nothing.
- R2: A `rx_push` pulse stores `rx_byte` in the inbound queue. A read of address 5 with `reg_rd` high returns the oldest byte in `reg_rdata[7:0]` and removes it.
- R3: Address 3 reads the queue counts. The inbound count starts at bit 0 and the outbound count starts at bit 16. Each field is wide enough to hold the depth (7 bits at depth 64).
- R4: Address 2 is the control word. It holds the inbound threshold in bits 7:0, the inbound flush in bit 15, the outbound threshold in bits 23:16 and the outbound flush in bit 31. Writing a flush bit empties its queue at that clock edge, and flush bits always read back as 0. Both thresholds reset to three quarters of the depth.
- R5: Pending bit 0 (inbound ready) is set on every cycle that follows a cycle in which the inbound count was at or above the inbound threshold.
- R6: Pending bit 4 (outbound request) is set on every cycle that follows a cycle in which the outbound count was at or below the outbound threshold.
- R7: Pending bit 8 (inbound overflow) is set when `rx_push` arrives while the inbound queue is full. That byte is dropped, and the stored contents stay unchanged.
- R8: Pending bit 12 (transfer complete) is set by a `xfer_done` pulse.
- R9: Address 1 reads the pending bits. Writing 1 to a bit clears it and writing 0 leaves it alone, so all ones clears everything. A clear beats a level condition in the write cycle, and the level bit returns one cycle later if its condition still holds. An event arriving in the same cycle as its clear stays pending.
- R10: Address 0 holds the enables at bits 0, 4, 8 and 12. `irq` is high exactly when some pending bit has its enable set.
- R11: After reset both queues are empty, the enables are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the inbound queue at address 5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address |
| tx_pop | input | 1 | Shift engine takes the oldest outbound byte |
| tx_byte | output | 8 | Oldest outbound byte |
| tx_empty | output | 1 | Outbound queue holds no bytes |
| rx_push | input | 1 | Shift engine delivers a byte |
| rx_byte | input | 8 | Delivered byte |
| rx_full | output | 1 | Inbound queue is at full depth |
| xfer_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count inside a queue shows at the ports within a few cycles. It appears as a byte out of order or repeated on `tx_byte` or on the inbound data read, or as a count field that disagrees with the bytes pushed and popped. Faults in the pending register show up in the status read one cycle after the count crosses a threshold. A level bit that fails to return after a clear, or an event lost when its clear lands in the same cycle, shows in the very next status read or in `irq`. An overflow that corrupts stored data only shows when the full queue is drained and a byte differs from the scoreboard.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

    localparam int NSRC          = 4;
    localparam int SRC_STRIDE    = 4;
    localparam int SRC_RX_READY  = 0;
    localparam int SRC_TX_REQ    = 1;
    localparam int SRC_RX_OVF    = 2;
    localparam int SRC_DONE      = 3;

    localparam int RX_TRIG_LSB   = 0;
    localparam int RX_FLUSH_BIT  = 15;
    localparam int TX_TRIG_LSB   = 16;
    localparam int TX_FLUSH_BIT  = 31;
    localparam int TX_CNT_LSB    = 16;

    typedef enum logic [2:0] {
        ADDR_IEN   = 3'd0,
        ADDR_ISTAT = 3'd1,
        ADDR_FCTL  = 3'd2,
        ADDR_FSTAT = 3'd3,
        ADDR_TXD   = 3'd4,
        ADDR_RXD   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [7:0] tx_trig;
        logic [7:0] rx_trig;
    } trig_t;

    function automatic logic [31:0] src_to_word(input logic [NSRC-1:0] s);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NSRC; i++) w[i*SRC_STRIDE] = s[i];
        return w;
    endfunction

    function automatic logic [NSRC-1:0] word_to_src(input logic [31:0] w);
        logic [NSRC-1:0] s;
        for (int i = 0; i < NSRC; i++) s[i] = w[i*SRC_STRIDE];
        return s;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R4
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0));

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] lvl_set,
    input  logic [NSRC-1:0] evt_set,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] stat,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= ((stat | lvl_set) & ~clr) | evt_set;
    end

    assign irq = |(stat & en);

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R9
        clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !evt_set[i]) |=> !stat[i]);
        // R9
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !clr[i]) |=> stat[i]);
        // R8
        evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
            evt_set[i] |=> stat[i]);
    end

endmodule

// File: rtl/spi_fifo_irq_top.sv
module spi_fifo_irq_top
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_empty,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    output logic        rx_full,
    input  logic        xfer_done,
    output logic        irq
);
    localparam logic [7:0] TRIG_RST = 8'(DEPTH / 4 * 3);

    reg_addr_e       addr;
    trig_t           trig;
    logic [NSRC-1:0] ien, stat, lvl_set, evt_set, clr;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic [7:0]      rx_dout;
    logic            tx_full_unused, rx_empty_unused;
    logic            wr_fctl, tx_push, rx_pop, tx_flush, rx_flush;

    assign addr     = reg_addr_e'(reg_addr);
    assign wr_fctl  = reg_wr && (addr == ADDR_FCTL);
    assign tx_flush = wr_fctl && reg_wdata[TX_FLUSH_BIT];
    assign rx_flush = wr_fctl && reg_wdata[RX_FLUSH_BIT];
    assign tx_push  = reg_wr && (addr == ADDR_TXD);
    assign rx_pop   = reg_rd && (addr == ADDR_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= '0;
            trig <= '{tx_trig: TRIG_RST, rx_trig: TRIG_RST};
        end else if (reg_wr) begin
            if (addr == ADDR_IEN) ien <= word_to_src(reg_wdata);
            if (addr == ADDR_FCTL) begin
                trig.rx_trig <= reg_wdata[RX_TRIG_LSB +: 8];
                trig.tx_trig <= reg_wdata[TX_TRIG_LSB +: 8];
            end
        end
    end

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_byte),
        .cnt(tx_cnt), .full(tx_full_unused), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout),
        .cnt(rx_cnt), .full(rx_full), .empty(rx_empty_unused)
    );

    always_comb begin
        lvl_set = '0;
        evt_set = '0;
        lvl_set[SRC_RX_READY] = (9'(rx_cnt) >= 9'(trig.rx_trig));
        lvl_set[SRC_TX_REQ]   = (9'(tx_cnt) <= 9'(trig.tx_trig));
        evt_set[SRC_RX_OVF]   = rx_push && rx_full;
        evt_set[SRC_DONE]     = xfer_done;
        clr = (reg_wr && addr == ADDR_ISTAT) ? word_to_src(reg_wdata) : '0;
    end

    irq_pending #(.NSRC(NSRC)) u_pending (
        .clk(clk), .rst(rst),
        .lvl_set(lvl_set), .evt_set(evt_set), .clr(clr), .en(ien),
        .stat(stat), .irq(irq)
    );

    always_comb begin
        case (addr)
            ADDR_IEN:   reg_rdata = src_to_word(ien);
            ADDR_ISTAT: reg_rdata = src_to_word(stat);
            ADDR_FCTL:  reg_rdata = (32'(trig.tx_trig) << TX_TRIG_LSB)
                                  | (32'(trig.rx_trig) << RX_TRIG_LSB);
            ADDR_FSTAT: reg_rdata = (32'(tx_cnt) << TX_CNT_LSB) | 32'(rx_cnt);
            ADDR_RXD:   reg_rdata = 32'(rx_dout);
            default:    reg_rdata = '0;
        endcase
    end

    // R7
    ovf_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full && !rx_pop && !rx_flush) |=> $stable(rx_cnt));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

endmodule

// File: tb/spi_fifo_irq_top_bench.sv
module spi_fifo_irq_top_bench;
    localparam int DEPTH = 64;

    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 0;
    logic [7:0]  tx_byte;
    logic        tx_empty;
    logic        rx_push = 0;
    logic [7:0]  rx_byte = 0;
    logic        rx_full;
    logic        xfer_done = 0;
    logic        irq;

    int checks = 0, errors = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #5 clk = ~clk;

    spi_fifo_irq_top #(.DEPTH(DEPTH)) u_spi_fifo_irq_top (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
        .xfer_done(xfer_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic pop, output logic [31:0] d);
        reg_addr = a; reg_rd = pop;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    // driver: push outbound byte and record expectation
    task automatic drv_tx(input logic [7:0] b);
        tx_q.push_back(b);
        wr(3'd4, {24'h0, b});
    endtask

    // monitor: take outbound byte and compare with scoreboard
    task automatic mon_tx(input string req);
        logic [7:0] e;
        e = tx_q.pop_front();
        check(req, {24'h0, tx_byte}, {24'h0, e});
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic drv_rx(input logic [7:0] b, input logic keep);
        if (keep) rx_q.push_back(b);
        rx_byte = b; rx_push = 1;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic mon_rx(input string req);
        logic [31:0] d;
        logic [7:0]  e;
        e = rx_q.pop_front();
        rd(3'd5, 1'b1, d);
        check(req, d, {24'h0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        @(negedge clk);

        // R11 reset state
        rd(3'd3, 0, d); check("R11 counts", d, 32'h0);
        rd(3'd0, 0, d); check("R11 enables", d, 32'h0);
        check("R11 irq", {31'h0, irq}, 32'h0);
        check("R11 tx_empty", {31'h0, tx_empty}, 32'h1);
        rd(3'd2, 0, d); check("R4 reset thresholds", d, 32'h0030_0030);
        rd(3'd1, 0, d); check("R6 request after reset", d, 32'h10);

        // R1/R3/R9 thresholds: rx 2, tx 1
        wr(3'd2, 32'h0001_0002);
        drv_tx(8'hA1); drv_tx(8'hB2); drv_tx(8'hC3);
        rd(3'd3, 0, d); check("R3 tx count field", d, 32'h0003_0000);
        wr(3'd1, 32'h10);
        rd(3'd1, 0, d); check("R9 clear above threshold", d, 32'h0);
        mon_tx("R1 order 1");
        mon_tx("R1 order 2");
        @(negedge clk);
        rd(3'd1, 0, d); check("R6 request at threshold", d, 32'h10);

        // R10 irq with enable; R9 level returns after clear
        wr(3'd0, 32'h10);
        check("R10 irq enabled", {31'h0, irq}, 32'h1);
        wr(3'd1, 32'h10);
        rd(3'd1, 0, d); check("R9 clear wins in write cycle", d, 32'h0);
        rd(3'd1, 0, d); check("R9 level returns", d, 32'h10);
        mon_tx("R1 order 3");
        check("R1 tx_empty", {31'h0, tx_empty}, 32'h1);
        wr(3'd0, 32'h0);
        check("R10 irq disabled", {31'h0, irq}, 32'h0);

        // R2/R5 inbound queue
        drv_rx(8'h11, 1); drv_rx(8'h22, 1);
        rd(3'd3, 0, d); check("R3 rx count field", d, 32'h0000_0002);
        rd(3'd1, 0, d); check("R5 ready at threshold", d, 32'h11);
        mon_rx("R2 read 1");
        mon_rx("R2 read 2");
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 0, d); check("R9 all ones clears", d, 32'h0);

        // R7 overflow
        for (int i = 0; i < DEPTH; i++) drv_rx(8'(i * 7 + 3), 1);
        check("R7 rx_full", {31'h0, rx_full}, 32'h1);
        drv_rx(8'hEE, 0);
        rd(3'd1, 0, d); check("R7 overflow bit", d & 32'h100, 32'h100);
        rd(3'd3, 0, d); check("R7 count unchanged", d, 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) mon_rx("R7 contents kept");
        rd(3'd3, 0, d); check("R2 drained", d, 32'h0);

        // R4 flush
        drv_tx(8'h5A); drv_tx(8'h6B);
        drv_rx(8'h77, 1);
        wr(3'd2, 32'h8001_8002);
        tx_q.delete(); rx_q.delete();
        rd(3'd3, 0, d); check("R4 flush empties", d, 32'h0);
        rd(3'd2, 0, d); check("R4 flush bits read 0", d, 32'h0001_0002);
        check("R4 tx_empty after flush", {31'h0, tx_empty}, 32'h1);

        // R8 transfer complete
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'h1000);
        xfer_done = 1; @(negedge clk); xfer_done = 0;
        check("R8 irq on done", {31'h0, irq}, 32'h1);
        rd(3'd1, 0, d); check("R8 done bit", d & 32'h1000, 32'h1000);
        wr(3'd1, 32'hFFFF_FFFF);
        check("R9 done cleared irq", {31'h0, irq}, 32'h0);

        // R9 event beats clear in the same cycle
        xfer_done = 1;
        wr(3'd1, 32'h1000);
        xfer_done = 0;
        rd(3'd1, 0, d); check("R9 event survives clear", d & 32'h1000, 32'h1000);
        check("R10 irq after event", {31'h0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule